// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block sits on the host side of an asynchronous parallel NOR flash bus. A client raises a one-cycle request that carries an operation code, a target address, a data word and a bus-width select. The block expands that request into the chain of write cycles the flash needs before it will act: a two-write unlock key, one or more command writes, and a final write. It issues these cycles through a simple bus master port with a ready handshake. Pin-level timing is handled by the bus controller behind that port.

The identification and query operations also perform follow-up read cycles. Each word read back is returned on a result port together with its position in the sequence. Command addresses are offsets from a parameterised bank base. In 16-bit mode each offset is doubled to form a byte address. Addresses supplied by the client are placed on the bus exactly as given. The block does not poll the flash for completion.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `busy`, `done`, `rsp_busy`, `rd_valid`, `bus_wr` and `bus_rd` are all low.
- R2: The program, identify, sector-erase and chip-erase sequences open with the same two writes: 0xAA to command offset 0x555, then 0x55 to command offset 0x2AA.
- R3: Program (`req_op`=2) makes four writes. The third is 0xA0 to offset 0x555. The fourth puts `req_data` at `req_addr`.
- R4: Identify (`req_op`=0) makes three writes, the last being 0x90 to offset 0x555. It then reads offsets 0x000, 0x001, 0x00E and 0x00F in that order, and each word read appears on `rd_data` with `rd_idx` 0 to 3.
- R5: Sector erase (`req_op`=3) makes six writes. After the key come 0x80@0x555, 0xAA@0x555 and 0x55@0x2AA, and the sixth write is 0x30 to `req_addr`.
- R6: Chip erase (`req_op`=4) repeats the first five writes of sector erase. Its sixth write is 0x10 to offset 0x555.
- R7: Query (`req_op`=5) is a single write of 0x98 to offset 0x055, followed by CFI_WORDS reads at offsets 0x010 upward, returned with `rd_idx` counting from 0.
- R8: Return-to-read (`req_op`=1) is a single write of 0xF0 to the bank base address.
- R9: A command offset goes on the bus as BANK_BASE + offset when `req_wide`=0 and as BANK_BASE + 2*offset when `req_wide`=1. The width select is latched when the request is accepted.
- R10: At most one strobe is high at a time. A strobe, its address and its write data stay unchanged until a cycle in which `bus_ready` is high, and that cycle completes the bus transfer.
- R11: `busy` goes high in the cycle after a request is accepted. `done` is a one-cycle pulse in the cycle after the last bus transfer completes, and `busy` is low in that same cycle.
- R12: A request made while `busy` is high raises `rsp_busy` in the next cycle and leaves the running sequence unchanged.
- R13: Operation codes 6 and 7 are ignored. They start no bus cycle, do not raise `busy` and give no `done`, and a later valid request still runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle operation request |
| req_op | input | 3 | Operation code (0 identify, 1 return-to-read, 2 program, 3 sector erase, 4 chip erase, 5 query) |
| req_addr | input | AW | Target byte address for program and sector erase |
| req_data | input | DW | Word to program |
| req_wide | input | 1 | 1: 16-bit flash, command offsets doubled; 0: 8-bit |
| busy | output | 1 | A sequence is running |
| rsp_busy | output | 1 | Previous-cycle request was refused |
| done | output | 1 | Sequence finished (one-cycle pulse) |
| bus_addr | output | AW | Bus byte address |
| bus_wdata | output | DW | Bus write data |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_ready | input | 1 | Current bus transfer completes this cycle |
| bus_rdata | input | DW | Bus read data, valid with bus_ready on a read |
| rd_valid | output | 1 | Captured read word is valid |
| rd_data | output | DW | Captured read word |
| rd_idx | output | RIX_W | Position of the word within its sequence |

## Verification
A wrong step counter or a wrong operation latch shows up on the bus address or write data at the first transfer that follows. The ready handshake lets each transfer be checked in the cycle it is presented. A wrong final-step decision appears one cycle after the last expected transfer, either as an extra strobe or as a `done` pulse that comes early or late. A fault in the read capture path shows on `rd_data` or `rd_idx` one cycle after the read completes. Stretching the ready response over several cycles exposes any strobe that drops, or any address that moves, before its transfer completes.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [2:0] {
        OP_READ_ID    = 3'd0,
        OP_TO_READ    = 3'd1,
        OP_PROGRAM    = 3'd2,
        OP_SECT_ERASE = 3'd3,
        OP_CHIP_ERASE = 3'd4,
        OP_CFI_QUERY  = 3'd5
    } nor_op_e;

    localparam logic [11:0] KEY_OFS_A    = 12'h555;
    localparam logic [11:0] KEY_OFS_B    = 12'h2AA;
    localparam logic [11:0] QUERY_OFS    = 12'h055;
    localparam logic [11:0] QUERY_DATA0  = 12'h010;
    localparam logic [11:0] ID_MFR_OFS   = 12'h000;
    localparam logic [11:0] ID_DEV1_OFS  = 12'h001;
    localparam logic [11:0] ID_DEV2_OFS  = 12'h00E;
    localparam logic [11:0] ID_DEV3_OFS  = 12'h00F;

    // One bus transfer of a sequence.
    typedef struct packed {
        logic        is_read;    // read transfer, else write
        logic        at_target;  // client address, else command offset
        logic        user_data;  // client word, else command byte
        logic [11:0] offset;     // command offset (unscaled)
        logic [7:0]  code;       // command byte
    } bus_step_t;

    function automatic logic op_known(input logic [2:0] code);
        return code <= 3'd5;
    endfunction

    function automatic int op_len(input nor_op_e op, input int cfi_n);
        case (op)
            OP_READ_ID:    return 7;
            OP_TO_READ:    return 1;
            OP_PROGRAM:    return 4;
            OP_SECT_ERASE: return 6;
            OP_CHIP_ERASE: return 6;
            OP_CFI_QUERY:  return 1 + cfi_n;
            default:       return 1;
        endcase
    endfunction

    function automatic bus_step_t mk_write(input logic [11:0] ofs, input logic [7:0] cmd);
        bus_step_t s;
        s.is_read   = 1'b0;
        s.at_target = 1'b0;
        s.user_data = 1'b0;
        s.offset    = ofs;
        s.code      = cmd;
        return s;
    endfunction

    function automatic bus_step_t mk_read(input logic [11:0] ofs);
        bus_step_t s;
        s = mk_write(ofs, 8'h00);
        s.is_read = 1'b1;
        return s;
    endfunction

    function automatic bus_step_t mk_target(input logic use_user, input logic [7:0] cmd);
        bus_step_t s;
        s = mk_write(12'h000, cmd);
        s.at_target = 1'b1;
        s.user_data = use_user;
        return s;
    endfunction

    // Transfer number idx of operation op.
    function automatic bus_step_t op_step(input nor_op_e op, input int idx);
        bus_step_t s;
        s = mk_write(12'h000, 8'hF0);
        case (op)
            OP_TO_READ: s = mk_write(12'h000, 8'hF0);
            OP_CFI_QUERY: begin
                if (idx == 0) s = mk_write(QUERY_OFS, 8'h98);
                else          s = mk_read(QUERY_DATA0 + 12'(idx - 1));
            end
            default: begin
                if (idx == 0)      s = mk_write(KEY_OFS_A, 8'hAA);
                else if (idx == 1) s = mk_write(KEY_OFS_B, 8'h55);
                else begin
                    case (op)
                        OP_PROGRAM: begin
                            if (idx == 2) s = mk_write(KEY_OFS_A, 8'hA0);
                            else          s = mk_target(1'b1, 8'h00);
                        end
                        OP_READ_ID: begin
                            case (idx)
                                2:       s = mk_write(KEY_OFS_A, 8'h90);
                                3:       s = mk_read(ID_MFR_OFS);
                                4:       s = mk_read(ID_DEV1_OFS);
                                5:       s = mk_read(ID_DEV2_OFS);
                                default: s = mk_read(ID_DEV3_OFS);
                            endcase
                        end
                        default: begin
                            case (idx)
                                2:       s = mk_write(KEY_OFS_A, 8'h80);
                                3:       s = mk_write(KEY_OFS_A, 8'hAA);
                                4:       s = mk_write(KEY_OFS_B, 8'h55);
                                default: s = (op == OP_SECT_ERASE) ? mk_target(1'b0, 8'h30)
                                                                   : mk_write(KEY_OFS_A, 8'h10);
                            endcase
                        end
                    endcase
                end
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
    import nor_seq_pkg::*;
#(
    parameter int AW        = 24,
    parameter int DW        = 16,
    parameter int CFI_WORDS = 3,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_data,
    input  logic             req_wide,
    input  logic             bus_ready,
    output logic             accept,
    output logic             busy,
    output logic             done,
    output logic             rsp_busy,
    output logic             bus_wr,
    output logic             bus_rd,
    output nor_op_e          op_q,
    output logic [IDX_W-1:0] idx_q,
    output logic [AW-1:0]    tgt_q,
    output logic [DW-1:0]    usr_q,
    output logic             wide_q
);

    bus_step_t first_step;
    bus_step_t next_step;
    logic      xfer_done;
    logic      last_step;

    assign accept     = req_valid && !busy && op_known(req_op);
    assign first_step = op_step(nor_op_e'(req_op), 0);
    assign next_step  = op_step(op_q, int'(idx_q) + 1);
    assign xfer_done  = busy && (bus_wr || bus_rd) && bus_ready;
    assign last_step  = (int'(idx_q) == op_len(op_q, CFI_WORDS) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            rsp_busy <= 1'b0;
            bus_wr   <= 1'b0;
            bus_rd   <= 1'b0;
            op_q     <= OP_TO_READ;
            idx_q    <= '0;
            tgt_q    <= '0;
            usr_q    <= '0;
            wide_q   <= 1'b0;
        end else begin
            done     <= 1'b0;
            rsp_busy <= req_valid && busy;
            if (accept) begin
                busy   <= 1'b1;
                op_q   <= nor_op_e'(req_op);
                idx_q  <= '0;
                tgt_q  <= req_addr;
                usr_q  <= req_data;
                wide_q <= req_wide;
                bus_rd <= first_step.is_read;
                bus_wr <= !first_step.is_read;
            end else if (xfer_done) begin
                if (last_step) begin
                    busy   <= 1'b0;
                    done   <= 1'b1;
                    bus_wr <= 1'b0;
                    bus_rd <= 1'b0;
                end else begin
                    idx_q  <= idx_q + 1'b1;
                    bus_rd <= next_step.is_read;
                    bus_wr <= !next_step.is_read;
                end
            end
        end
    end

endmodule

// File: rtl/nor_seq_addr.sv
module nor_seq_addr
    import nor_seq_pkg::*;
#(
    parameter int          AW        = 24,
    parameter int          DW        = 16,
    parameter logic [AW-1:0] BANK_BASE = '0
) (
    input  bus_step_t     step,
    input  logic          wide,
    input  logic [AW-1:0] tgt,
    input  logic [DW-1:0] usr,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata
);

    logic [AW-1:0] ofs_ext;
    logic [AW-1:0] ofs_scaled;

    assign ofs_ext    = AW'(step.offset);
    assign ofs_scaled = wide ? (ofs_ext << 1) : ofs_ext;
    assign bus_addr   = step.at_target ? tgt : (BANK_BASE + ofs_scaled);
    assign bus_wdata  = step.user_data ? usr : DW'(step.code);

endmodule

// File: rtl/nor_seq_capture.sv
module nor_seq_capture #(
    parameter int DW    = 16,
    parameter int RIX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             bus_rd,
    input  logic             bus_ready,
    input  logic [DW-1:0]    bus_rdata,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic [RIX_W-1:0] rd_idx
);

    logic [RIX_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_idx   <= '0;
            count_q  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (clear) begin
                count_q <= '0;
            end else if (bus_rd && bus_ready) begin
                rd_valid <= 1'b1;
                rd_data  <= bus_rdata;
                rd_idx   <= count_q;
                count_q  <= count_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int            AW        = 24,
    parameter int            DW        = 16,
    parameter int            CFI_WORDS = 3,
    parameter logic [AW-1:0] BANK_BASE = 24'h100000,
    localparam int           RD_MAX    = (CFI_WORDS > 4) ? CFI_WORDS : 4,
    localparam int           RIX_W     = $clog2(RD_MAX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_data,
    input  logic             req_wide,
    output logic             busy,
    output logic             rsp_busy,
    output logic             done,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_wdata,
    output logic             bus_wr,
    output logic             bus_rd,
    input  logic             bus_ready,
    input  logic [DW-1:0]    bus_rdata,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic [RIX_W-1:0] rd_idx
);

    localparam int IDX_W = $clog2(CFI_WORDS + 8);

    logic             accept;
    nor_op_e          op_q;
    logic [IDX_W-1:0] idx_q;
    logic [AW-1:0]    tgt_q;
    logic [DW-1:0]    usr_q;
    logic             wide_q;
    bus_step_t        cur_step;

    nor_seq_ctrl #(
        .AW(AW), .DW(DW), .CFI_WORDS(CFI_WORDS), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data), .req_wide(req_wide), .bus_ready(bus_ready),
        .accept(accept), .busy(busy), .done(done), .rsp_busy(rsp_busy),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .op_q(op_q), .idx_q(idx_q),
        .tgt_q(tgt_q), .usr_q(usr_q), .wide_q(wide_q)
    );

    assign cur_step = op_step(op_q, int'(idx_q));

    nor_seq_addr #(
        .AW(AW), .DW(DW), .BANK_BASE(BANK_BASE)
    ) u_addr (
        .step(cur_step), .wide(wide_q), .tgt(tgt_q), .usr(usr_q),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata)
    );

    nor_seq_capture #(
        .DW(DW), .RIX_W(RIX_W)
    ) u_cap (
        .clk(clk), .rst(rst), .clear(accept),
        .bus_rd(bus_rd), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_idx(rd_idx)
    );

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic [2:0]    req_op,
    input logic          busy,
    input logic          rsp_busy,
    input logic          done,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic          bus_ready,
    input logic          rd_valid
);

    p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_rd));

    p_hold_until_ready_r10: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_rd) && !bus_ready) |=>
        (bus_wr == $past(bus_wr)) && (bus_rd == $past(bus_rd)) &&
        $stable(bus_addr) && $stable(bus_wdata));

    p_quiet_when_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!bus_wr && !bus_rd));

    p_done_after_xfer_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy && bus_ready && (bus_wr || bus_rd)));

    p_done_clears_busy_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_refuse_only_when_busy_r12: assert property (@(posedge clk) disable iff (rst)
        rsp_busy |-> $past(req_valid && busy));

    p_capture_after_read_r4: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(bus_rd && bus_ready));

    p_start_needs_known_op_r13: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid && (req_op <= 3'd5)));

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .busy(busy), .rsp_busy(rsp_busy), .done(done),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ready(bus_ready),
    .rd_valid(rd_valid)
);

// File: tb/sim_nor_cmd_seq.sv
module sim_nor_cmd_seq;

    localparam int          CLK_PERIOD = 10;
    localparam int          AW         = 24;
    localparam int          DW         = 16;
    localparam int          CFI_N      = 3;
    localparam logic [23:0] BASE       = 24'h100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = 3'd0;
    logic [23:0]   req_addr = '0;
    logic [15:0]   req_data = '0;
    logic          req_wide = 1'b0;
    logic          busy, rsp_busy, done;
    logic [23:0]   bus_addr;
    logic [15:0]   bus_wdata;
    logic          bus_wr, bus_rd;
    logic          bus_ready = 1'b0;
    logic [15:0]   bus_rdata = '0;
    logic          rd_valid;
    logic [15:0]   rd_data;
    logic [1:0]    rd_idx;

    int total = 0;
    int bad   = 0;

    bit          e_rd   [16];
    logic [23:0] e_addr [16];
    logic [15:0] e_data [16];
    int          e_n;
    int          e_reads;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_cmd_seq #(
        .AW(AW), .DW(DW), .CFI_WORDS(CFI_N), .BANK_BASE(BASE)
    ) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_wide(req_wide),
        .busy(busy), .rsp_busy(rsp_busy), .done(done),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_idx(rd_idx)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [23:0] cmd_at(input logic [11:0] ofs, input bit wide);
        return BASE + (wide ? (24'(ofs) << 1) : 24'(ofs));
    endfunction

    task automatic push_wr(input logic [23:0] a, input logic [15:0] d);
        e_rd[e_n] = 1'b0; e_addr[e_n] = a; e_data[e_n] = d; e_n++;
    endtask

    task automatic push_rd(input logic [23:0] a);
        e_rd[e_n] = 1'b1; e_addr[e_n] = a; e_data[e_n] = '0; e_n++; e_reads++;
    endtask

    // Expected transfers, built from the requirements.
    task automatic build_exp(input logic [2:0] op, input logic [23:0] tgt,
                             input logic [15:0] dat, input bit w);
        e_n = 0; e_reads = 0;
        if (op == 3'd1) begin
            push_wr(BASE, 16'h00F0);
        end else if (op == 3'd5) begin
            push_wr(cmd_at(12'h055, w), 16'h0098);
            for (int k = 0; k < CFI_N; k++) push_rd(cmd_at(12'h010 + 12'(k), w));
        end else begin
            push_wr(cmd_at(12'h555, w), 16'h00AA);
            push_wr(cmd_at(12'h2AA, w), 16'h0055);
            if (op == 3'd2) begin
                push_wr(cmd_at(12'h555, w), 16'h00A0);
                push_wr(tgt, dat);
            end else if (op == 3'd0) begin
                push_wr(cmd_at(12'h555, w), 16'h0090);
                push_rd(cmd_at(12'h000, w));
                push_rd(cmd_at(12'h001, w));
                push_rd(cmd_at(12'h00E, w));
                push_rd(cmd_at(12'h00F, w));
            end else begin
                push_wr(cmd_at(12'h555, w), 16'h0080);
                push_wr(cmd_at(12'h555, w), 16'h00AA);
                push_wr(cmd_at(12'h2AA, w), 16'h0055);
                if (op == 3'd3) push_wr(tgt, 16'h0030);
                else            push_wr(cmd_at(12'h555, w), 16'h0010);
            end
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [23:0] tgt,
                          input logic [15:0] dat, input bit w, input int waits,
                          input bit intrude, input string tag);
        int i, hold, cyc, rd_seen, ready_cyc;
        bit done_seen, intruded, want_refuse, seq_ok;
        logic [15:0] pend;
        build_exp(op, tgt, dat, w);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = tgt; req_data = dat; req_wide = w;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R11", "busy after accept", busy, 1);
        i = 0; hold = 0; cyc = 0; rd_seen = 0; ready_cyc = -5;
        done_seen = 0; intruded = 0; want_refuse = 0; seq_ok = 1; pend = '0;
        while (!done_seen && cyc < 300) begin
            bus_ready = 1'b0;
            if (want_refuse) begin
                chk(rsp_busy == 1'b1, "R12", "refusal flag", rsp_busy, 1);
                req_valid = 1'b0;
                want_refuse = 0;
            end
            if (rd_valid) begin
                chk(rd_data == pend, tag, "read word", rd_data, pend);
                chk(int'(rd_idx) == rd_seen, tag, "read index", rd_idx, rd_seen);
                rd_seen++;
            end
            if (done) begin
                done_seen = 1;
                chk(cyc == ready_cyc + 1, "R11", "done timing", cyc, ready_cyc + 1);
                chk(busy == 1'b0, "R11", "busy with done", busy, 0);
            end else if (bus_wr || bus_rd) begin
                if (i >= e_n) begin
                    if (seq_ok) chk(0, tag, "extra transfer", i, e_n);
                    seq_ok = 0;
                end else if (bus_rd != e_rd[i] || bus_wr == e_rd[i] ||
                             bus_addr != e_addr[i] ||
                             (!e_rd[i] && bus_wdata != e_data[i])) begin
                    if (seq_ok)
                        chk(0, tag, $sformatf("transfer %0d addr/data", i),
                            {bus_addr, bus_wdata}, {e_addr[i], e_data[i]});
                    seq_ok = 0;
                end
                if (hold >= waits) begin
                    bus_ready = 1'b1;
                    pend = 16'hB000 + 16'(i * 17) + 16'(op);
                    bus_rdata = pend;
                    hold = 0; i++; ready_cyc = cyc;
                end else begin
                    hold++;
                end
                if (intrude && !intruded && i == 2) begin
                    req_valid = 1'b1; req_op = 3'd4; req_addr = 24'h0; req_wide = ~w;
                    intruded = 1; want_refuse = 1;
                end
            end
            @(negedge clk);
            cyc++;
        end
        bus_ready = 1'b0;
        chk(seq_ok, tag, "transfer sequence matched", seq_ok, 1);
        chk(done_seen, tag, "done seen", done_seen, 1);
        chk(i == e_n, tag, "transfer count", i, e_n);
        chk(rd_seen == e_reads, tag, "read words returned", rd_seen, e_reads);
        @(negedge clk);
        chk(!busy && !done && !bus_wr && !bus_rd, "R11", "idle after done",
            {busy, done, bus_wr, bus_rd}, 0);
    endtask

    task automatic test_reset();
        chk(!busy && !done && !rsp_busy && !rd_valid && !bus_wr && !bus_rd, "R1",
            "outputs after reset", {busy, done, rsp_busy, rd_valid, bus_wr, bus_rd}, 0);
    endtask

    task automatic test_undefined(input logic [2:0] op);
        bit quiet;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = 24'h0; req_wide = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        quiet = 1;
        for (int k = 0; k < 5; k++) begin
            if (busy || done || bus_wr || bus_rd || rsp_busy) quiet = 0;
            @(negedge clk);
        end
        chk(quiet, "R13", $sformatf("code %0d ignored", op), quiet, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        run_op(3'd1, 24'h0,      16'h0,    1'b1, 0, 1'b0, "R8");
        run_op(3'd2, 24'h00A246, 16'h5A3C, 1'b1, 2, 1'b0, "R3");
        run_op(3'd2, 24'h000123, 16'hC0DE, 1'b0, 0, 1'b0, "R9");
        run_op(3'd0, 24'h0,      16'h0,    1'b1, 1, 1'b0, "R4");
        run_op(3'd3, 24'h020000, 16'h0,    1'b0, 0, 1'b0, "R5");
        run_op(3'd4, 24'h0,      16'h0,    1'b1, 3, 1'b0, "R6");
        run_op(3'd5, 24'h0,      16'h0,    1'b1, 0, 1'b0, "R7");
        run_op(3'd5, 24'h0,      16'h0,    1'b0, 1, 1'b0, "R9");
        run_op(3'd2, 24'h004400, 16'h1234, 1'b1, 1, 1'b1, "R12");
        run_op(3'd3, 24'h030000, 16'h0,    1'b1, 2, 1'b0, "R2");
        test_undefined(3'd6);
        test_undefined(3'd7);
        run_op(3'd1, 24'h0,      16'h0,    1'b0, 1, 1'b0, "R13");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule